// File: doc/BRIEF.md
# Serial EEPROM Boot Configuration Loader

After reset this block acts as a serial bus master and copies one page of default settings from an external serial EEPROM into the chip's configuration registers. It generates the serial clock by dividing the system clock. It selects the EEPROM and sends the EEPROM read command followed by a one-byte start address. It then clocks in a fixed number of data bytes and presents each byte on a register write port with an ascending register index.

A two-bit page selector picks one of four equal pages, so a 256-byte EEPROM can hold four alternative register sets. The selector is captured while reset is held and is ignored afterwards. When the last byte has been written, the block raises a sticky done flag and releases chip select. The serial clock keeps toggling so that the EEPROM sees a running clock at all times.

Top module: `boot_cfg_loader`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `spi_cs_n`=1, `spi_sclk`=0, `spi_mosi`=0, `cfg_we`=0 and `boot_done`=0.
- R2: Once reset is released, `spi_sclk` toggles every SCLK_DIV/2 system clocks, giving a period of SCLK_DIV clocks with 50% duty. It keeps running after `boot_done`, so with the default SCLK_DIV=4 any 40 consecutive clocks contain exactly 10 rising edges.
- R3: `spi_cs_n` falls only while `spi_sclk` is low, before the first rising edge of the transfer. It stays low for exactly 16 + 8*NUM_BYTES rising edges of `spi_sclk` (528 by default), then rises while `spi_sclk` is low.
- R4: The first 16 bits on `spi_mosi` are the read command 0x03 followed by an 8-bit address, both MSB first. `spi_mosi` changes only on the system edge where `spi_sclk` falls, and the EEPROM samples it on the rising edge.
- R5: The start address is `boot_page`*64. `boot_page` is taken from the last clock edge at which `rst` is high, and later changes to `boot_page` have no effect on the address or on the data loaded.
- R6: `spi_miso` is sampled at the rising edges of `spi_sclk`, starting with the 17th rising edge after chip select falls. Each group of 8 samples forms one byte, MSB first.
- R7: Each received byte produces one `cfg_we` pulse one system clock long. `cfg_idx` runs 0,1,...,63 in order, and `cfg_data` equals EEPROM byte (start address + `cfg_idx`). Exactly 64 strobes occur per boot.
- R8: `boot_done` rises after the strobe for index 63 and stays high until the next reset. After it rises there are no further strobes, and chip select stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; the load starts when it is released |
| boot_page | input | 2 | Selects the 64-byte page inside the EEPROM |
| spi_miso | input | 1 | Serial data from the EEPROM |
| spi_cs_n | output | 1 | Active-low EEPROM select |
| spi_sclk | output | 1 | Serial clock, free running after reset |
| spi_mosi | output | 1 | Serial command and address to the EEPROM |
| cfg_we | output | 1 | One-cycle configuration register write strobe |
| cfg_idx | output | 6 | Configuration register index of the write |
| cfg_data | output | 8 | Configuration register write data |
| boot_done | output | 1 | Sticky load-complete flag |

## Verification
The assertions assume that reset is a clean synchronous level held for at least one clock. They also assume that `spi_miso` is only relevant at rising serial-clock edges, so its value at other times is never checked. The bench EEPROM model drives `spi_miso` only on falling serial-clock edges while selected, and it changes reset and `boot_page` only at falling system-clock edges. Each run flips `boot_page` to a different page after reset is released, which checks that the captured page alone determines the address and the data.

// File: rtl/boot_cfg_pkg.sv
package boot_cfg_pkg;

  // Read command understood by the serial EEPROM
  localparam logic [7:0] EE_READ_OP = 8'h03;

  typedef enum logic [1:0] {
    LD_IDLE   = 2'd0,  // waiting for a falling serial clock edge
    LD_XFER   = 2'd1,  // command, address and data bits
    LD_FINISH = 2'd2,  // last byte written, release select
    LD_DONE   = 2'd3   // stay here until reset
  } ld_state_t;

endpackage

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int SCLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic sclk,
  output logic rise_tick,
  output logic fall_tick
);

  localparam int HALF = SCLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] div_cnt;
  logic          half_end;

  assign half_end = (div_cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      sclk    <= 1'b0;
    end else if (half_end) begin
      div_cnt <= '0;
      sclk    <= ~sclk;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  // Each tick marks the system edge on which the serial clock changes
  assign rise_tick = half_end & ~sclk;
  assign fall_tick = half_end &  sclk;

endmodule

// File: rtl/boot_seq.sv
module boot_seq
  import boot_cfg_pkg::*;
#(
  parameter int NUM_BYTES = 64,
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 2,
  localparam int IDX_W    = $clog2(NUM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PAGE_W-1:0] boot_page,
  input  logic              sclk,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              miso,
  output logic              cs_n,
  output logic              mosi,
  output logic              reg_we,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [7:0]        reg_data,
  output logic              done
);

  localparam int CMD_BITS   = 8 + ADDR_W;
  localparam int TOTAL_BITS = CMD_BITS + 8 * NUM_BYTES;
  localparam int CNT_W      = $clog2(TOTAL_BITS + 1);

  ld_state_t             state;
  logic [PAGE_W-1:0]     page_q;
  logic [ADDR_W-1:0]     base_addr;
  logic [CMD_BITS-1:0]   cmd_sr;
  logic [CMD_BITS-1:0]   cmd_word;
  logic [7:0]            rx_sr;
  logic [IDX_W-1:0]      byte_idx;
  logic [CNT_W-1:0]      rise_cnt;
  logic [CNT_W-1:0]      data_pos;
  logic                  in_data;
  logic                  byte_end;

  // Page offset: NUM_BYTES is a power of two, so a shift places the page
  assign base_addr = ADDR_W'(page_q) << IDX_W;
  assign cmd_word  = {EE_READ_OP, base_addr};
  assign in_data   = (rise_cnt >= CNT_W'(CMD_BITS));
  assign data_pos  = rise_cnt - CNT_W'(CMD_BITS);
  assign byte_end  = in_data && (data_pos[2:0] == 3'd7);

  // Page selector is captured while reset is held, frozen afterwards
  always_ff @(posedge clk) begin
    if (rst) page_q <= boot_page;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= LD_IDLE;
      cs_n     <= 1'b1;
      mosi     <= 1'b0;
      reg_we   <= 1'b0;
      reg_idx  <= '0;
      reg_data <= '0;
      done     <= 1'b0;
      cmd_sr   <= '0;
      rx_sr    <= '0;
      byte_idx <= '0;
      rise_cnt <= '0;
    end else begin
      reg_we <= 1'b0;
      unique case (state)
        LD_IDLE: begin
          if (fall_tick) begin
            cs_n     <= 1'b0;
            mosi     <= cmd_word[CMD_BITS-1];
            cmd_sr   <= cmd_word << 1;
            rise_cnt <= '0;
            byte_idx <= '0;
            state    <= LD_XFER;
          end
        end
        LD_XFER: begin
          if (rise_tick) begin
            rise_cnt <= rise_cnt + 1'b1;
            if (in_data) begin
              rx_sr <= {rx_sr[6:0], miso};
              if (byte_end) begin
                reg_we   <= 1'b1;
                reg_idx  <= byte_idx;
                reg_data <= {rx_sr[6:0], miso};
                byte_idx <= byte_idx + 1'b1;
              end
            end
            if (rise_cnt == CNT_W'(TOTAL_BITS - 1)) state <= LD_FINISH;
          end else if (fall_tick) begin
            if (in_data) begin
              mosi <= 1'b0;
            end else begin
              mosi   <= cmd_sr[CMD_BITS-1];
              cmd_sr <= cmd_sr << 1;
            end
          end
        end
        LD_FINISH: begin
          done <= 1'b1;
          if (fall_tick) begin
            cs_n  <= 1'b1;
            state <= LD_DONE;
          end
        end
        LD_DONE: begin
          done <= 1'b1;
        end
        default: state <= LD_IDLE;
      endcase
    end
  end

  // Select changes only while the serial clock is low
  assert_cs_edge_low_sclk_R3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(cs_n)) |-> !sclk);

  // Outgoing bits move only with a falling serial clock
  assert_mosi_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mosi)) |-> $fell(sclk));

  // Captured page never moves during a transfer
  assert_page_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (!cs_n) |-> $stable(page_q));

  // Write strobe is a single-cycle pulse
  assert_we_single_R7: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // Done is sticky until reset
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  // Nothing further happens on the write port or select after done
  assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!reg_we && !$fell(cs_n)));

endmodule

// File: rtl/boot_cfg_loader.sv
module boot_cfg_loader #(
  parameter int SCLK_DIV  = 4,
  parameter int NUM_BYTES = 64,
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [PAGE_W-1:0]            boot_page,
  input  logic                         spi_miso,
  output logic                         spi_cs_n,
  output logic                         spi_sclk,
  output logic                         spi_mosi,
  output logic                         cfg_we,
  output logic [$clog2(NUM_BYTES)-1:0] cfg_idx,
  output logic [7:0]                   cfg_data,
  output logic                         boot_done
);

  logic sclk_i;
  logic rise_tick;
  logic fall_tick;

  sclk_gen #(
    .SCLK_DIV (SCLK_DIV)
  ) u_sclk (
    .clk       (clk),
    .rst       (rst),
    .sclk      (sclk_i),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  boot_seq #(
    .NUM_BYTES (NUM_BYTES),
    .ADDR_W    (ADDR_W),
    .PAGE_W    (PAGE_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .boot_page (boot_page),
    .sclk      (sclk_i),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .miso      (spi_miso),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi),
    .reg_we    (cfg_we),
    .reg_idx   (cfg_idx),
    .reg_data  (cfg_data),
    .done      (boot_done)
  );

  assign spi_sclk = sclk_i;

endmodule

// File: tb/boot_cfg_loader_bench.sv
module boot_cfg_loader_bench;

  localparam int DIV   = 4;
  localparam int NB    = 64;
  localparam int XBITS = 16 + 8 * NB;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] boot_page = 2'd0;
  logic       miso = 1'b0;
  logic       cs_n, sclk, mosi, we, done;
  logic [5:0] idx;
  logic [7:0] data;

  always #10 clk = ~clk;  // 50 MHz

  boot_cfg_loader #(.SCLK_DIV(DIV), .NUM_BYTES(NB)) u_boot_cfg_loader (
    .clk(clk), .rst(rst), .boot_page(boot_page), .spi_miso(miso),
    .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .cfg_we(we), .cfg_idx(idx), .cfg_data(data), .boot_done(done)
  );

  int checks = 0;
  int errors = 0;

  function automatic logic [7:0] ee_byte(input int a);
    logic [7:0] x;
    x = 8'(a);
    return (x * 8'd29 + 8'd7) ^ (x >> 3);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- EEPROM model ----------------
  int          m_bits = 0;
  logic [15:0] m_cmd = '0;
  int          m_rises = 0;
  logic        m_sclk_at_sel = 1'b0;
  logic        m_sclk_at_rel = 1'b0;

  always @(negedge cs_n) begin
    m_bits = 0; m_cmd = '0; m_rises = 0; m_sclk_at_sel = sclk;
  end
  always @(posedge cs_n) begin
    miso = 1'b0; m_sclk_at_rel = sclk;
  end
  always @(posedge sclk) begin
    if (!cs_n) begin
      if (m_bits < 16) m_cmd = {m_cmd[14:0], mosi};
      m_bits++;
      m_rises++;
    end
  end
  always @(negedge sclk) begin
    if (!cs_n && m_bits >= 16) begin
      int d;
      logic [7:0] b;
      d = m_bits - 16;
      b = ee_byte(int'(m_cmd[7:0]) + d / 8);
      miso = b[7 - (d % 8)];
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { int idx; int data; } exp_t;
  exp_t exp_q[$];
  int   wr_seen = 0;

  always @(negedge clk) begin
    if (!rst && we) begin
      wr_seen++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", "unexpected strobe idx", int'(idx), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(int'(idx) == e.idx, "R7", "register index", int'(idx), e.idx);
        check(int'(data) == e.data, "R6 R7", "register data", int'(data), e.data);
      end
    end
  end

  task automatic run_boot(input int page, input int alt_page);
    int waited;
    int rises;
    logic prev;
    bit done_hold;
    rst = 1'b1;
    boot_page = 2'(page);
    repeat (4) @(negedge clk);
    // R1: reset state
    check(cs_n == 1'b1, "R1", "cs_n in reset", int'(cs_n), 1);
    check(sclk == 1'b0, "R1", "sclk in reset", int'(sclk), 0);
    check(mosi == 1'b0, "R1", "mosi in reset", int'(mosi), 0);
    check(we == 1'b0, "R1", "we in reset", int'(we), 0);
    check(done == 1'b0, "R1", "done in reset", int'(done), 0);
    wr_seen = 0;
    exp_q.delete();
    for (int i = 0; i < NB; i++) begin
      exp_t e;
      e.idx  = i;
      e.data = int'(ee_byte(page * 64 + i));
      exp_q.push_back(e);
    end
    rst = 1'b0;
    repeat (2) @(negedge clk);
    boot_page = 2'(alt_page);  // R5: must be ignored
    waited = 0;
    while (!done && waited < 10000) begin
      @(negedge clk);
      waited++;
    end
    check(done == 1'b1, "R8", "done raised", int'(done), 1);
    check(wr_seen == NB, "R7", "strobe count", wr_seen, NB);
    check(exp_q.size() == 0, "R7", "pending items", exp_q.size(), 0);
    check(m_cmd[15:8] == 8'h03, "R4", "opcode", int'(m_cmd[15:8]), 3);
    check(int'(m_cmd[7:0]) == page * 64, "R5", "start address", int'(m_cmd[7:0]), page * 64);
    check(m_sclk_at_sel == 1'b0, "R3", "sclk at select", int'(m_sclk_at_sel), 0);
    repeat (DIV) @(negedge clk);
    check(cs_n == 1'b1, "R8", "select released", int'(cs_n), 1);
    check(m_rises == XBITS, "R3", "rises while selected", m_rises, XBITS);
    check(m_sclk_at_rel == 1'b0, "R3", "sclk at release", int'(m_sclk_at_rel), 0);
    // R2 and R8: clock keeps running, done stays, no more strobes
    rises = 0;
    done_hold = 1'b1;
    prev = sclk;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (sclk && !prev) rises++;
      prev = sclk;
      if (!done) done_hold = 1'b0;
    end
    check(rises == 40 / DIV, "R2", "sclk rises in 40 clocks", rises, 40 / DIV);
    check(done_hold, "R8", "done sticky", int'(done_hold), 1);
    check(wr_seen == NB, "R8", "no strobes after done", wr_seen, NB);
    check(cs_n == 1'b1, "R8", "select stays released", int'(cs_n), 1);
  endtask

  initial begin
    run_boot(0, 3);
    run_boot(1, 2);
    run_boot(2, 0);
    run_boot(3, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule